// File: doc/BRIEF.md
# SDIO Read-Wait Controller

This block sits on the host side of an SD/SDIO bus. During card-to-host data transfers it carries out the read-wait operation, which holds off the card between blocks. Two methods are available. In the signalling method the block pulls the DAT2 line low, and on release it returns DAT2 to high through a single high pulse. In the clock-gating method the block withholds the card clock shortly after a block's end bit. Command handling, CRC computation and data shifting stay in the neighbouring logic. The data receiver supplies a block-busy level and an end-of-block strobe.

The controller runs on one system clock. A card-clock enable strobe (`ck_tick`) marks each card clock period, and every state change waits for it, except the abort to idle. The card clock is produced elsewhere from this strobe, gated by `ck_en`. While a read-wait interval is active, the DAT1 line is watched for an SDIO interrupt. DAT1 is active low and passes through a two-flop synchronizer. The resulting flag is sticky until software clears it.

Top module: `sdrw_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (idle), `dat2_oe` is 0, `ck_en` is 1 and `irq_flag` is 0. The state encoding is: 0 idle, 1 waiting for data, 2 signalling lead-in, 3 DAT2 held low, 4 stop tail, 5 high pulse, 6 clock-gate lead-in, 7 clock gated.
- R2: The controller is engaged when `path_en`, `sdio_en` and `dir_rx` are all 1. On a tick from idle it enters state 2 if `rw_start`=1, `rw_stop`=0, `rw_clkstop`=0 and `blk_busy`=0. Otherwise it enters state 1.
- R3: The lead-in (state 2) lasts 2 ticks. The controller then enters state 3 and drives DAT2 low (`dat2_oe`=1, `dat2_out`=0).
- R4: A tick with `rw_stop`=1 in state 2 or 3 moves to state 4. State 4 keeps DAT2 low for 2 ticks. State 5 then drives DAT2 high for exactly one tick, and state 1 follows with DAT2 released (`dat2_oe`=0).
- R5: No interval starts while `blk_busy`=1, even with `rw_start`=1. The interval starts on the first tick after `blk_busy` falls.
- R6: While `rw_stop` stays 1, no new interval of either method starts from state 1.
- R7: With `rw_clkstop`=1, a tick in state 1 with `blk_done`=1, `rw_start`=1 and `rw_stop`=0 enters state 6. After 2 ticks the controller enters state 7, where `ck_en`=0.
- R8: In state 7, a tick with `rw_start`=0 or `rw_stop`=1 returns to state 1 and sets `ck_en` back to 1.
- R9: If any of `path_en`, `sdio_en` or `dir_rx` is 0, the state is 0 on the next clock whether or not a tick occurs. DAT2 is then released and `ck_en` is 1.
- R10: The flag sets when the synchronized DAT1 is 0 while in state 3 or 4. It then stays set until `irq_clr`=1, which clears it and wins over a set. DAT1 low in any other state does not set it.
- R11: While engaged, the state does not change on a clock without `ck_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_tick | input | 1 | One-clock strobe per card clock period |
| path_en | input | 1 | Data path enable |
| sdio_en | input | 1 | SDIO-specific operation enable |
| rw_start | input | 1 | Read-wait request |
| rw_stop | input | 1 | Read-wait release |
| rw_clkstop | input | 1 | 1 selects the clock-gating method |
| dir_rx | input | 1 | 1 when data flows card to host |
| blk_busy | input | 1 | A block is being received |
| blk_done | input | 1 | End bit / CRC of a block received |
| dat1_in | input | 1 | DAT1 line, interrupt active low |
| irq_clr | input | 1 | Clears the interrupt flag |
| dat2_out | output | 1 | DAT2 drive value |
| dat2_oe | output | 1 | DAT2 output enable |
| ck_en | output | 1 | Card clock enable |
| irq_flag | output | 1 | Sticky SDIO interrupt flag |
| state_o | output | 3 | Controller state code |

## Verification
On every cycle, the assertions check several properties:
- the abort to idle when the transfer is disengaged;
- that no interval is entered while a block is busy or the release bit is set;
- the single-tick high pulse;
- that the clock is gated only in the gated state;
- the stickiness and clear priority of the interrupt flag;
- state stability between ticks.

Only the bench scenarios can show that each lead-in and tail lasts exactly two ticks and that the method order runs end to end. The same holds for the synchronizer latency before the flag sets and for the clock-gating entry after a block end. The bench compares all outputs against a behavioural model every clock.

// File: rtl/sdrw_pkg.sv
package sdrw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT     = 3'd1,
    ST_RW_LEAD  = 3'd2,
    ST_RW_HOLD  = 3'd3,
    ST_RW_TAIL  = 3'd4,
    ST_RW_PULSE = 3'd5,
    ST_CK_LEAD  = 3'd6,
    ST_CK_STOP  = 3'd7
  } rw_state_e;
endpackage

// File: rtl/sdrw_sync.sv
module sdrw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/sdrw_fsm.sv
module sdrw_fsm
  import sdrw_pkg::*;
#(
  parameter int LEAD_TICKS   = 2,
  parameter int TAIL_TICKS   = 2,
  parameter int CKGATE_TICKS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ck_tick,
  input  logic      engaged,
  input  logic      rw_start,
  input  logic      rw_stop,
  input  logic      rw_clkstop,
  input  logic      blk_busy,
  input  logic      blk_done,
  output rw_state_e state_q
);
  localparam int MAX_T = (LEAD_TICKS > TAIL_TICKS)
                         ? ((LEAD_TICKS > CKGATE_TICKS) ? LEAD_TICKS : CKGATE_TICKS)
                         : ((TAIL_TICKS > CKGATE_TICKS) ? TAIL_TICKS : CKGATE_TICKS);
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_TICKS - 1);
  localparam logic [CNT_W-1:0] CKG_LD  = CNT_W'(CKGATE_TICKS - 1);

  rw_state_e        state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_ok, rw_sig_go, ck_gate_go, cnt_zero;

  assign start_ok   = rw_start && !rw_stop;
  assign rw_sig_go  = start_ok && !rw_clkstop && !blk_busy;
  assign ck_gate_go = start_ok && rw_clkstop && blk_done;
  assign cnt_zero   = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!engaged) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (ck_tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (rw_sig_go) begin
            state_d = ST_RW_LEAD;
            cnt_d   = LEAD_LD;
          end else begin
            state_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rw_sig_go) begin
            state_d = ST_RW_LEAD;
            cnt_d   = LEAD_LD;
          end else if (ck_gate_go) begin
            state_d = ST_CK_LEAD;
            cnt_d   = CKG_LD;
          end
        end
        ST_RW_LEAD: begin
          if (rw_stop) begin
            state_d = ST_RW_TAIL;
            cnt_d   = TAIL_LD;
          end else if (cnt_zero) begin
            state_d = ST_RW_HOLD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_RW_HOLD: begin
          if (rw_stop) begin
            state_d = ST_RW_TAIL;
            cnt_d   = TAIL_LD;
          end
        end
        ST_RW_TAIL: begin
          if (cnt_zero) state_d = ST_RW_PULSE;
          else          cnt_d   = cnt_q - 1'b1;
        end
        ST_RW_PULSE: state_d = ST_WAIT;
        ST_CK_LEAD: begin
          if (cnt_zero) state_d = ST_CK_STOP;
          else          cnt_d   = cnt_q - 1'b1;
        end
        ST_CK_STOP: begin
          if (!start_ok) state_d = ST_WAIT;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sdrw_outdec.sv
module sdrw_outdec
  import sdrw_pkg::*;
(
  input  rw_state_e state,
  output logic      dat2_out,
  output logic      dat2_oe,
  output logic      ck_en,
  output logic      irq_window
);
  always_comb begin
    dat2_out   = 1'b1;
    dat2_oe    = 1'b0;
    ck_en      = 1'b1;
    irq_window = 1'b0;
    unique case (state)
      ST_RW_HOLD, ST_RW_TAIL: begin
        dat2_out   = 1'b0;
        dat2_oe    = 1'b1;
        irq_window = 1'b1;
      end
      ST_RW_PULSE: begin
        dat2_out = 1'b1;
        dat2_oe  = 1'b1;
      end
      ST_CK_STOP: ck_en = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/sdrw_irq.sv
module sdrw_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dat1_in,
  input  logic window,
  input  logic clr,
  output logic flag_q
);
  logic dat1_s, flag_d;

  sdrw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (dat1_in),
    .d_out (dat1_s)
  );

  always_comb begin
    flag_d = flag_q;
    if (clr)                    flag_d = 1'b0;
    else if (window && !dat1_s) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/sdrw_ctrl.sv
module sdrw_ctrl
  import sdrw_pkg::*;
#(
  parameter int LEAD_TICKS   = 2,
  parameter int TAIL_TICKS   = 2,
  parameter int CKGATE_TICKS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ck_tick,
  input  logic       path_en,
  input  logic       sdio_en,
  input  logic       rw_start,
  input  logic       rw_stop,
  input  logic       rw_clkstop,
  input  logic       dir_rx,
  input  logic       blk_busy,
  input  logic       blk_done,
  input  logic       dat1_in,
  input  logic       irq_clr,
  output logic       dat2_out,
  output logic       dat2_oe,
  output logic       ck_en,
  output logic       irq_flag,
  output logic [2:0] state_o
);
  rw_state_e state;
  logic      engaged, irq_window;

  assign engaged = path_en && sdio_en && dir_rx;

  sdrw_fsm #(
    .LEAD_TICKS   (LEAD_TICKS),
    .TAIL_TICKS   (TAIL_TICKS),
    .CKGATE_TICKS (CKGATE_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ck_tick    (ck_tick),
    .engaged    (engaged),
    .rw_start   (rw_start),
    .rw_stop    (rw_stop),
    .rw_clkstop (rw_clkstop),
    .blk_busy   (blk_busy),
    .blk_done   (blk_done),
    .state_q    (state)
  );

  sdrw_outdec u_dec (
    .state      (state),
    .dat2_out   (dat2_out),
    .dat2_oe    (dat2_oe),
    .ck_en      (ck_en),
    .irq_window (irq_window)
  );

  sdrw_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .dat1_in (dat1_in),
    .window  (irq_window),
    .clr     (irq_clr),
    .flag_q  (irq_flag)
  );

  assign state_o = state;
endmodule

// File: rtl/sdrw_ctrl_chk.sv
module sdrw_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ck_tick,
  input logic       path_en,
  input logic       sdio_en,
  input logic       rw_start,
  input logic       rw_stop,
  input logic       rw_clkstop,
  input logic       dir_rx,
  input logic       blk_busy,
  input logic       blk_done,
  input logic       dat1_in,
  input logic       irq_clr,
  input logic       dat2_out,
  input logic       dat2_oe,
  input logic       ck_en,
  input logic       irq_flag,
  input logic [2:0] state_o
);
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(path_en && sdio_en && dir_rx) |=> (state_o == 3'd0 && !dat2_oe && ck_en));

  p_busy_blocks_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_busy && state_o != 3'd2) |=> state_o != 3'd2);

  p_stop_blocks_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && rw_stop) |=> (state_o != 3'd2 && state_o != 3'd6));

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && ck_tick) |=> (state_o != 3'd5 && !dat2_oe));

  p_clock_gate_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_en |-> (state_o == 3'd7 && !dat2_oe));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_flag);

  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_tick && path_en && sdio_en && dir_rx) |=> $stable(state_o));
endmodule

bind sdrw_ctrl sdrw_ctrl_chk u_chk (.*);

// File: tb/sdrw_ctrl_test.sv
`timescale 1ns/1ps
module sdrw_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, ck_tick = 1'b0;
  logic path_en = 0, sdio_en = 0, rw_start = 0, rw_stop = 0, rw_clkstop = 0;
  logic dir_rx = 0, blk_busy = 0, blk_done = 0, dat1_in = 1, irq_clr = 0;
  logic dat2_out, dat2_oe, ck_en, irq_flag;
  logic [2:0] state_o;
  int n_chk = 0, n_fail = 0, tdiv = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdrw_ctrl uut (.*);

  always @(negedge clk) begin
    tdiv    <= (tdiv + 1) % 4;
    ck_tick <= (tdiv == 2);
  end

  // behavioural reference model
  int m_st, m_spent, m_s1, m_s2, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_spent = 0; m_s1 = 1; m_s2 = 1; m_irq = 0;
    end else begin
      automatic bit eng = path_en && sdio_en && dir_rx;
      automatic bit ok  = rw_start && !rw_stop;
      automatic int nirq = irq_clr ? 0 : ((m_irq != 0 || ((m_st == 3 || m_st == 4) && m_s2 == 0)) ? 1 : 0);
      m_s2 = m_s1; m_s1 = dat1_in; m_irq = nirq;
      if (!eng) m_st = 0;
      else if (ck_tick) begin
        case (m_st)
          0, 1: begin
            if (ok && !rw_clkstop && !blk_busy) begin m_st = 2; m_spent = 0; end
            else if (m_st == 1 && ok && rw_clkstop && blk_done) begin m_st = 6; m_spent = 0; end
            else m_st = 1;
          end
          2: begin
            m_spent++;
            if (rw_stop) begin m_st = 4; m_spent = 0; end
            else if (m_spent == 2) m_st = 3;
          end
          3: if (rw_stop) begin m_st = 4; m_spent = 0; end
          4: begin m_spent++; if (m_spent == 2) m_st = 5; end
          5: m_st = 1;
          6: begin m_spent++; if (m_spent == 2) m_st = 7; end
          7: if (!ok) m_st = 1;
          default: m_st = 0;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("MODEL state", state_o, m_st);
      chk("MODEL dat2_oe", dat2_oe, (m_st >= 3 && m_st <= 5) ? 1 : 0);
      if (dat2_oe) chk("MODEL dat2_out", dat2_out, (m_st == 5) ? 1 : 0);
      chk("MODEL ck_en", ck_en, (m_st == 7) ? 0 : 1);
      chk("MODEL irq_flag", irq_flag, m_irq);
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!ck_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 dat2_oe", dat2_oe, 0);
    chk("R1 ck_en", ck_en, 1);
    chk("R1 irq_flag", irq_flag, 0);

    // R2 entry from idle, signalling method
    path_en = 1; sdio_en = 1; dir_rx = 1; rw_start = 1;
    wait_ticks(1);
    chk("R2 lead from idle", state_o, 2);
    // R11 no change without a tick
    @(negedge clk);
    chk("R11 stable between ticks", state_o, 2);
    // R3 two tick lead-in
    wait_ticks(1);
    chk("R3 still lead after 1 tick", state_o, 2);
    wait_ticks(1);
    chk("R3 hold state", state_o, 3);
    chk("R3 dat2_oe", dat2_oe, 1);
    chk("R3 dat2_out low", dat2_out, 0);

    // R10 interrupt on DAT1
    dat1_in = 0;
    repeat (4) @(negedge clk);
    chk("R10 flag set", irq_flag, 1);
    dat1_in = 1;
    repeat (3) @(negedge clk);
    chk("R10 flag sticky", irq_flag, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R10 flag cleared", irq_flag, 0);

    // R4 stop sequence
    rw_stop = 1;
    wait_ticks(1);
    chk("R4 tail", state_o, 4);
    chk("R4 tail drives low", dat2_out, 0);
    wait_ticks(1);
    chk("R4 tail second tick", state_o, 4);
    wait_ticks(1);
    chk("R4 pulse", state_o, 5);
    chk("R4 pulse high", dat2_out, 1);
    chk("R4 pulse oe", dat2_oe, 1);
    wait_ticks(1);
    chk("R4 back to wait", state_o, 1);
    chk("R4 released", dat2_oe, 0);

    // R6 stop held blocks new interval
    wait_ticks(2);
    chk("R6 no restart while stop", state_o, 1);

    // R5 busy blocks start
    rw_stop = 0; blk_busy = 1;
    wait_ticks(2);
    chk("R5 no start while busy", state_o, 1);
    blk_busy = 0;
    wait_ticks(1);
    chk("R5 start after block", state_o, 2);

    // R9 abort by path disable
    path_en = 0;
    @(negedge clk);
    chk("R9 idle after path off", state_o, 0);
    path_en = 1;
    wait_ticks(3);
    chk("R9 setup hold", state_o, 3);
    sdio_en = 0;
    @(negedge clk);
    chk("R9 idle after sdio off", state_o, 0);
    chk("R9 dat2 released", dat2_oe, 0);
    sdio_en = 1;

    // R2 / R7 / R8 clock-gating method
    rw_clkstop = 1; blk_busy = 1;
    wait_ticks(1);
    chk("R2 wait when clock mode", state_o, 1);
    dat1_in = 0;
    repeat (4) @(negedge clk);
    chk("R10 no flag outside window", irq_flag, 0);
    dat1_in = 1;
    rw_stop = 1; blk_busy = 0; blk_done = 1;
    wait_ticks(1);
    chk("R6 no clock gate while stop", state_o, 1);
    rw_stop = 0;
    wait_ticks(1);
    blk_done = 0;
    chk("R7 clock lead", state_o, 6);
    chk("R7 clock still on", ck_en, 1);
    wait_ticks(2);
    chk("R7 clock gated state", state_o, 7);
    chk("R7 ck_en low", ck_en, 0);
    wait_ticks(2);
    chk("R8 stays gated", ck_en, 0);
    rw_start = 0;
    wait_ticks(1);
    chk("R8 released to wait", state_o, 1);
    chk("R8 ck_en high", ck_en, 1);

    // R8 release by stop, then R9 abort by direction
    rw_start = 1; blk_done = 1;
    wait_ticks(3);
    blk_done = 0;
    chk("R7 gated again", state_o, 7);
    rw_stop = 1;
    wait_ticks(1);
    chk("R8 release by stop", ck_en, 1);
    rw_stop = 0; blk_done = 1;
    wait_ticks(3);
    blk_done = 0;
    dir_rx = 0;
    @(negedge clk);
    chk("R9 idle after direction change", state_o, 0);
    chk("R9 clock re-enabled", ck_en, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule